// File: doc/BRIEF.md
# Synchronizable Third-Order Sinc Decimation Filter

This block turns a 1-bit sigma-delta modulator stream into 16-bit output words. The filter is a cascade of three running-sum integrators clocked by each accepted modulator sample and three first-difference comb stages clocked once per output word. Together they implement the cube of an N-sample averaging kernel, (1/N)^3 · ((1 − z^−N)/(1 − z^−1))^3. The comb result is normalised by N^3 and presented as an unsigned 16-bit fraction of full scale. A 2-bit rate code picks N at run time: the notch positions move with N while the shape of the response stays the same.

Samples arrive on `mod_stb` (one strobe per modulator sample, for example one per 128 master clocks). An active-high synchronous `sync` input holds all filter state at zero and restarts decimation when it is released. Because a third-order kernel needs three word periods of clean input, a small controller withholds `dout_valid` until the output has settled. The controller has three states. In HOLD, `sync` is high. In SETTLE, words are being discarded. In RUN, words are flagged. Its transitions are:
- any state to HOLD while `sync` is high;
- HOLD to SETTLE on release, with 2 words to discard;
- any state to SETTLE on a rate-code change, with 3 words to discard;
- SETTLE to RUN on the word that uses up the discard count.

Reset enters SETTLE with 3 words to discard.

Top module: `sinc3_decim`

## Requirements
- R1: The rate code sets the decimation ratio N: code 0 gives 960, code 1 gives 768, code 2 gives 192 and code 3 gives 160 samples per word.
- R2: A word is formed on the N-th accepted sample counted from each restart. Its raw value S is the weighted sum of the last 3N−2 samples, each counting 1 for a high bit and 0 for a low bit. The weights are those of three cascaded N-long box windows.
- R3: `dout` equals min(65535, (S · floor(2^46 / N^3)) >> 30). A constant high stream therefore settles to 65535, and a constant low stream settles to 0.
- R4: `dout_valid` is a single-cycle pulse, visible two clock edges after the edge that accepts the word-completing sample. `dout` changes only with that pulse.
- R5: While `sync` is high, strobed samples are ignored and the filter state is zero. After release, sample history starts empty, the first two words are discarded and the third is flagged.
- R6: When the rate code differs from the applied code (without `sync`), the sample count restarts and the integrator history is kept. Three words are discarded and the fourth is flagged.
- R7: After reset, `dout` is 0 and `dout_valid` is low, with empty history and rate code 0 applied. The first three words are discarded.
- R8: A cycle with `mod_stb` low takes no sample, whatever the value of `mod_bit`.
- R9: A rate-code change made while `sync` is high takes effect at once. The post-release discard is the two-word rule of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_stb | input | 1 | Modulator sample strobe |
| mod_bit | input | 1 | Modulator bit, taken when `mod_stb` is high |
| rate_sel | input | 2 | Decimation rate code |
| sync | input | 1 | Synchronous filter restart, active high |
| dout | output | 16 | Normalised filter word |
| dout_valid | output | 1 | One-cycle flag for a settled word |

## Verification
The effect of a corrupted integrator or comb register depends on the stage. A corrupted integrator shows up as a wrong `dout` at the next flagged word. It clears only once the combs have differenced it out, which takes up to three word periods. A corrupted comb delay spoils the following words in the same way. A wrong sample count or discard count shows up as a flagged word at the wrong cycle, or as a missing or extra pulse. It is visible one to four word periods after the restart that caused it. The scoreboard therefore compares every flagged word's value and arrival cycle against a windowed-sum model. It does this at all four rate codes and after reset, `sync` and rate changes.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2
    } ctrl_state_t;

    localparam logic [1:0] SYNC_DISCARD    = 2'd2;
    localparam logic [1:0] RESTART_DISCARD = 2'd3;

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    // floor(2^(frac+ow) / n^order): fixed-point reciprocal of the DC gain
    function automatic longint unsigned scale_recip(int unsigned n, int unsigned order,
                                                    int unsigned frac, int unsigned ow);
        longint unsigned p;
        p = 64'd1;
        for (int unsigned i = 0; i < order; i++) p = p * longint'(n);
        return (64'd1 << (frac + ow)) / p;
    endfunction

endpackage

// File: rtl/sinc3_rate_lut.sv
module sinc3_rate_lut #(
    parameter int unsigned RATIO_0 = 960,
    parameter int unsigned RATIO_1 = 768,
    parameter int unsigned RATIO_2 = 192,
    parameter int unsigned RATIO_3 = 160,
    parameter int unsigned ORDER   = 3,
    parameter int unsigned CNT_W   = 10,
    parameter int unsigned FRAC    = 30,
    parameter int unsigned OUT_W   = 16,
    parameter int unsigned RECIP_W = 47
) (
    input  logic [1:0]         code,
    output logic [CNT_W-1:0]   ratio_m1,
    output logic [RECIP_W-1:0] recip
);

    function automatic int unsigned ratio_of(int unsigned c);
        case (c)
            0:       return RATIO_0;
            1:       return RATIO_1;
            2:       return RATIO_2;
            default: return RATIO_3;
        endcase
    endfunction

    logic [3:0][CNT_W-1:0]   m1_tbl;
    logic [3:0][RECIP_W-1:0] rc_tbl;

    for (genvar g = 0; g < 4; g++) begin : g_code
        localparam int unsigned NV = ratio_of(g);
        localparam longint unsigned RC = sinc3_pkg::scale_recip(NV, ORDER, FRAC, OUT_W);
        assign m1_tbl[g] = CNT_W'(NV - 1);
        assign rc_tbl[g] = RECIP_W'(RC);
    end

    assign ratio_m1 = m1_tbl[code];
    assign recip    = rc_tbl[code];

endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int unsigned ACC_W = 31,
    parameter int unsigned ORDER = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             stb,
    input  logic             bit_in,
    output logic [ACC_W-1:0] sum_next
);

    logic [ACC_W-1:0] acc [ORDER];
    logic [ACC_W-1:0] nxt [ORDER];

    // each stage adds the freshly updated value of the stage before it
    always_comb begin
        nxt[0] = acc[0] + {{(ACC_W-1){1'b0}}, bit_in};
        for (int k = 1; k < ORDER; k++) nxt[k] = acc[k] + nxt[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < ORDER; k++) acc[k] <= '0;
        end else if (clr) begin
            for (int k = 0; k < ORDER; k++) acc[k] <= '0;
        end else if (stb) begin
            for (int k = 0; k < ORDER; k++) acc[k] <= nxt[k];
        end
    end

    assign sum_next = nxt[ORDER-1];

    // R5
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc[0] == '0 && acc[ORDER-1] == '0));

    // R8
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb && !clr) |=> ($stable(acc[0]) && $stable(acc[ORDER-1])));

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int unsigned ACC_W = 31,
    parameter int unsigned ORDER = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fire,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] result
);

    logic [ACC_W-1:0] dly  [ORDER];
    logic [ACC_W-1:0] diff [ORDER];

    always_comb begin
        diff[0] = din - dly[0];
        for (int k = 1; k < ORDER; k++) diff[k] = diff[k-1] - dly[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < ORDER; k++) dly[k] <= '0;
            result <= '0;
        end else if (clr) begin
            for (int k = 0; k < ORDER; k++) dly[k] <= '0;
            result <= '0;
        end else if (fire) begin
            dly[0] <= din;
            for (int k = 1; k < ORDER; k++) dly[k] <= diff[k-1];
            result <= diff[ORDER-1];
        end
    end

    // R4
    comb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !clr) |=> $stable(result));

endmodule

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    input  logic             stb,
    input  logic [1:0]       rate_sel,
    input  logic [CNT_W-1:0] ratio_m1,
    output logic [1:0]       rate_q,
    output logic             fire,
    output logic             word_flag
);

    import sinc3_pkg::*;

    ctrl_state_t      state, nstate;
    logic [1:0]       rem, nrem;
    logic [CNT_W-1:0] cnt;
    logic             rate_chg;

    assign rate_chg = (rate_sel != rate_q);

    // sample counter and applied rate code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            rate_q <= 2'd0;
        end else if (sync || rate_chg) begin
            cnt    <= '0;
            rate_q <= rate_sel;
        end else if (stb) begin
            cnt <= (cnt == ratio_m1) ? '0 : cnt + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SETTLE;
            rem   <= RESTART_DISCARD;
        end else begin
            state <= nstate;
            rem   <= nrem;
        end
    end

    // next state
    always_comb begin
        nstate = state;
        nrem   = rem;
        if (sync) begin
            nstate = ST_HOLD;
        end else if (rate_chg) begin
            nstate = ST_SETTLE;
            nrem   = RESTART_DISCARD;
        end else begin
            unique case (state)
                ST_HOLD: begin
                    nstate = ST_SETTLE;
                    nrem   = SYNC_DISCARD;
                end
                ST_SETTLE: begin
                    if (fire) begin
                        if (rem == 2'd1) nstate = ST_RUN;
                        else             nrem   = rem - 2'd1;
                    end
                end
                ST_RUN:  nstate = ST_RUN;
                default: nstate = ST_SETTLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        fire      = stb && !sync && !rate_chg && (cnt == ratio_m1);
        word_flag = fire && (state == ST_RUN);
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= ratio_m1);

    // R6
    rate_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && rate_sel != rate_q) |=> (cnt == '0 && state == ST_SETTLE && rem == RESTART_DISCARD));

    // R5
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (state == ST_HOLD && cnt == '0));

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
    parameter int unsigned RATIO_0 = 960,
    parameter int unsigned RATIO_1 = 768,
    parameter int unsigned RATIO_2 = 192,
    parameter int unsigned RATIO_3 = 160,
    parameter int unsigned ORDER   = 3,
    parameter int unsigned OUT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_stb,
    input  logic             mod_bit,
    input  logic [1:0]       rate_sel,
    input  logic             sync,
    output logic [OUT_W-1:0] dout,
    output logic             dout_valid
);

    localparam int unsigned NMAX    = sinc3_pkg::max4(RATIO_0, RATIO_1, RATIO_2, RATIO_3);
    localparam int unsigned CNT_W   = $clog2(NMAX);
    localparam int unsigned ACC_W   = 1 + ORDER * CNT_W;
    localparam int unsigned FRAC    = ACC_W - 1;
    localparam int unsigned RECIP_W = FRAC + OUT_W + 1;
    localparam int unsigned PROD_W  = ACC_W + RECIP_W;

    logic [1:0]         rate_q;
    logic [CNT_W-1:0]   ratio_m1;
    logic [RECIP_W-1:0] recip;
    logic               fire, word_flag;
    logic [ACC_W-1:0]   integ_sum, comb_sum;

    sinc3_rate_lut #(
        .RATIO_0(RATIO_0), .RATIO_1(RATIO_1), .RATIO_2(RATIO_2), .RATIO_3(RATIO_3),
        .ORDER(ORDER), .CNT_W(CNT_W), .FRAC(FRAC), .OUT_W(OUT_W), .RECIP_W(RECIP_W)
    ) lut_i (
        .code(rate_q), .ratio_m1(ratio_m1), .recip(recip)
    );

    sinc3_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .sync(sync), .stb(mod_stb), .rate_sel(rate_sel),
        .ratio_m1(ratio_m1), .rate_q(rate_q), .fire(fire), .word_flag(word_flag)
    );

    sinc3_integ #(.ACC_W(ACC_W), .ORDER(ORDER)) integ_i (
        .clk(clk), .rst_n(rst_n), .clr(sync), .stb(mod_stb), .bit_in(mod_bit),
        .sum_next(integ_sum)
    );

    sinc3_comb #(.ACC_W(ACC_W), .ORDER(ORDER)) comb_i (
        .clk(clk), .rst_n(rst_n), .clr(sync), .fire(fire), .din(integ_sum),
        .result(comb_sum)
    );

    // normalisation stage: one register slice after the comb result
    logic               keep_q;
    logic [RECIP_W-1:0] recip_q;
    logic [PROD_W-1:0]  prod, scaled;
    logic [OUT_W-1:0]   norm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep_q  <= 1'b0;
            recip_q <= '0;
        end else begin
            keep_q <= word_flag;
            if (fire) recip_q <= recip;
        end
    end

    always_comb begin
        prod   = PROD_W'(comb_sum) * PROD_W'(recip_q);
        scaled = prod >> FRAC;
        norm   = (scaled > PROD_W'({OUT_W{1'b1}})) ? {OUT_W{1'b1}} : scaled[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= keep_q;
            if (keep_q) dout <= norm;
        end
    end

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |=> !dout_valid);

    // R4
    dout_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(keep_q) |-> $stable(dout));

    // R5
    sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync, 2) |-> !dout_valid);

endmodule

// File: tb/sinc3_decim_tb_top.sv
module sinc3_decim_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_stb = 1'b0;
    logic        mod_bit = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic        sync = 1'b0;
    logic [15:0] dout;
    logic        dout_valid;

    always #2 clk = ~clk;   // 250 MHz

    sinc3_decim dut_i (
        .clk(clk), .rst_n(rst_n), .mod_stb(mod_stb), .mod_bit(mod_bit),
        .rate_sel(rate_sel), .sync(sync), .dout(dout), .dout_valid(dout_valid)
    );

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        int unsigned val;
        longint      at;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    // behavioural model state
    int              mN;
    int              mcnt;
    int              mrem;
    bit              mrun;
    bit              sync_on = 1'b0;
    byte             xs[$];
    int              w3[];
    longint unsigned mrecip;
    string           cur_tag = "R7";
    logic [15:0]     lfsr = 16'hACE1;

    task automatic chk(bit ok, string tag, longint got, longint exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp_v);
        end
    endtask

    // R1: ratio for each code
    function automatic int ratio_of(int code);
        case (code)
            0:       return 960;
            1:       return 768;
            2:       return 192;
            default: return 160;
        endcase
    endfunction

    // triple box-window weights for the current N, and the R3 reciprocal
    task automatic set_weights();
        int w2[];
        int s;
        w2 = new[2*mN-1];
        w3 = new[3*mN-2];
        for (int j = 0; j < 2*mN-1; j++) w2[j] = ((j < 2*mN-2-j) ? j : 2*mN-2-j) + 1;
        s = 0;
        for (int j = 0; j < 3*mN-2; j++) begin
            if (j <= 2*mN-2) s += w2[j];
            if (j >= mN)     s -= w2[j-mN];
            w3[j] = s;
        end
        mrecip = (64'd1 << 46) / (longint'(mN) * mN * mN);
    endtask

    task automatic model_accept(bit b, longint at);
        longint unsigned s, e;
        int n;
        exp_t it;
        if (sync_on) return;
        xs.push_back(byte'(b));
        while (xs.size() > 3000) void'(xs.pop_front());
        mcnt++;
        if (mcnt == mN) begin
            mcnt = 0;
            if (mrun) begin
                n = xs.size() - 1;
                s = 0;
                for (int j = 0; j < 3*mN-2; j++)
                    if (n - j >= 0 && xs[n-j] != 0) s += longint'(w3[j]);
                e = (s * mrecip) >> 30;
                if (e > 65535) e = 65535;
                it.val = int'(e);
                it.at  = at;
                it.tag = cur_tag;
                sb_q.push_back(it);
            end else if (mrem == 1) begin
                mrun = 1'b1;
            end else begin
                mrem--;
            end
        end
    endtask

    // one sample: strobe for a cycle, then an idle cycle with a flipped bit (R8)
    task automatic drive_sample(bit b);
        @(negedge clk);
        mod_stb = 1'b1;
        mod_bit = b;
        model_accept(b, cyc + 2);
        @(negedge clk);
        mod_stb = 1'b0;
        mod_bit = ~b;
    endtask

    task automatic run_const(bit b, int nsamp);
        for (int i = 0; i < nsamp; i++) drive_sample(b);
    endtask

    task automatic run_prbs(int nsamp);
        for (int i = 0; i < nsamp; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive_sample(lfsr[0]);
        end
    endtask

    task automatic do_rate(int code);
        @(negedge clk);
        rate_sel = 2'(code);
        mN = ratio_of(code);
        set_weights();
        mcnt = 0;
        mrem = 3;
        mrun = 1'b0;
    endtask

    // sync with strobes while held; optional rate change during the hold (R9)
    task automatic do_sync(int nstb, int new_code);
        @(negedge clk);
        sync = 1'b1;
        sync_on = 1'b1;
        xs.delete();
        mcnt = 0;
        mrem = 2;
        mrun = 1'b0;
        for (int i = 0; i < nstb; i++) begin
            @(negedge clk);
            mod_stb = 1'b1;
            mod_bit = 1'b1;
            if (i == nstb/2 && new_code >= 0) begin
                rate_sel = 2'(new_code);
                mN = ratio_of(new_code);
                set_weights();
            end
            @(negedge clk);
            mod_stb = 1'b0;
        end
        @(negedge clk);
        sync = 1'b0;
        sync_on = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && dout_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2/R4 unexpected word", longint'(dout), -1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (dout != 16'(e.val) || cyc != e.at)
                    $display("FAIL %s/R4: got %0d at cycle %0d expected %0d at cycle %0d",
                             e.tag, dout, cyc, e.val, e.at);
                n_cmp++;
                if (dout != 16'(e.val) || cyc != e.at) n_bad++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        mN = ratio_of(0);
        set_weights();
        mcnt = 0;
        mrem = 3;
        mrun = 1'b0;
        repeat (5) @(negedge clk);
        // R7: reset state
        chk(dout == 16'd0, "R7 reset dout", longint'(dout), 0);
        chk(dout_valid == 1'b0, "R7 reset valid", longint'(dout_valid), 0);
        rst_n = 1'b1;

        for (int code = 0; code < 4; code++) begin
            if (code != 0) do_rate(code);
            cur_tag = (code == 0) ? "R1/R3/R7 ones" : "R1/R3/R6 ones";
            run_const(1'b1, 6*mN);
            cur_tag = "R2/R3 zeros";
            run_const(1'b0, 3*mN);
            cur_tag = "R2 step";
            run_const(1'b1, (5*mN)/2);
            cur_tag = "R2/R8 prbs";
            run_prbs(4*mN);
        end

        // R5: sync clears history and discards two words
        cur_tag = "R5 sync";
        run_prbs(100);
        do_sync(20, -1);
        run_prbs(5*mN);

        // R9: rate change while sync is held
        cur_tag = "R9 sync+rate";
        do_sync(20, 2);
        run_prbs(4*mN);

        // R6: rate change without sync keeps history, discards three words
        do_rate(3);
        cur_tag = "R6 rate restart";
        run_prbs(5*mN);

        repeat (10) @(negedge clk);
        chk(sb_q.size() == 0, "R2 missing words", longint'(sb_q.size()), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule